// File: doc/BRIEF.md
# Pulse Pattern Sequencer

This block runs a stored program of 128-bit instructions that paints a 32-bit output pattern over time. Each instruction carries a mask of bits to raise, a mask of bits to lower, a 32-bit hold time and a small control operation. The sequencer fetches one instruction, applies its masks to the pattern, performs its control step, and then holds the pattern for the instruction's hold time before it fetches the next one. Halt, continue, counted loops (which may nest), subroutine call and return, and an unconditional jump make up the control repertoire. Loop counters and return addresses share one hardware stack.

The program memory lives outside the block. The sequencer presents a word address and expects the addressed word one clock later. A run is started in one of two ways. A software run pulse starts it when internal start is selected. A rising edge on a gate input starts it when external start is selected, and in that mode the run lasts only while the gate stays high. The program counter, stack depth and remaining hold time are brought out as status, along with a running flag and a sticky fault flag for stack misuse.

The controller has five states. IDLE waits for a start. FETCH presents the program counter to memory. LOAD captures the returned word. APPLY updates the pattern, performs the control step and loads the hold counter. HOLD counts the hold time down. The transitions are:
- IDLE→FETCH on start.
- FETCH→LOAD and LOAD→APPLY unconditionally.
- APPLY→IDLE on halt or on a stack fault.
- APPLY→HOLD when the hold time is nonzero, and APPLY→FETCH when it is zero.
- HOLD→FETCH on the last count.
- Any busy state→IDLE when external start is selected and the gate is low.

Top module: `patseq_core`

## Requirements
- R1: After reset the pattern is 0, running is 0, fault is 0, the stack depth is 0 and the hold count is 0.
- R2: Applying an instruction sets pattern to (pattern AND NOT clear) OR set, where set is bits 31:0 and clear is bits 63:32. A bit that is in both masks ends up 1. The pattern changes only while the sequencer is running.
- R3: Each executed instruction keeps its new pattern for exactly 3 plus its hold count cycles (hold count in bits 95:64) before the next instruction's pattern appears.
- R4: With internal start selected, a run pulse while idle starts execution at start_addr and clears the stack and the fault flag. A run pulse while running has no effect.
- R5: The operation code sits in bits 119:116. Code 0 (halt) applies its masks and then drops running in the same cycle, with no hold.
- R6: Code 2 (loop start) pushes the address of the next instruction together with the count in bits 115:96, where a count of 0 is taken as 1. Code 3 (loop end) jumps back while the top count is above 1 and decrements it, and otherwise pops and falls through. Loops nest.
- R7: Code 4 (call) pushes the return address and jumps to the target held in the low bits of bits 115:96. Code 5 (return) pops and resumes at the pushed address.
- R8: Code 6 (jump) continues at the target held in the low bits of bits 115:96 and leaves the stack unchanged.
- R9: Code 1 and codes 7 to 15 continue to the next address. Bits 127:120 have no effect.
- R10: A push onto a full stack halts the run and raises fault. The fault stays high until the next start. The stack depth never exceeds STACK_DEPTH.
- R11: A return or loop end on an empty stack halts the run and raises fault.
- R12: With external start selected, run pulses are ignored, a rising edge of ext_start starts the run, and ext_start low during a run stops it on the next clock edge. The instruction that would have been applied on that edge has no effect.
- R13: pc_o shows the next address to fetch, sp_o the stack depth, and dly_o the remaining hold cycles. dly_o is loaded with the hold count when an instruction is applied and then falls by one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Software start pulse (internal start mode) |
| ext_sel | input | 1 | 1 selects the external start gate |
| ext_start | input | 1 | External start gate |
| start_addr | input | PC_W | First instruction address of a run |
| prog_addr | output | PC_W | Program memory read address |
| prog_data | input | 128 | Program word, valid one cycle after its address |
| pattern | output | 32 | Pattern outputs |
| running | output | 1 | High while a program executes |
| fault | output | 1 | Sticky stack overflow or underflow flag |
| pc_o | output | PC_W | Program counter status |
| sp_o | output | $clog2(STACK_DEPTH+1) | Stack depth status |
| dly_o | output | 32 | Remaining hold cycles |

## Verification
The collision that needs the most care is an external stop that arrives on the same edge where an instruction is applied. The pattern update, stack push and jump compete with the return to IDLE on that edge. The bench drops the gate in the cycle just before an APPLY edge of a call instruction. It then requires that running falls, that the pattern keeps the previous instruction's value without the call's set mask, and that the stack depth stays 0. A second case overlaps a run pulse with an instruction already executing. The recorded trace has to match the one predicted for an undisturbed run.

// File: rtl/patseq_pkg.sv
package patseq_pkg;

    localparam int INSN_W  = 128;
    localparam int PAT_W   = 32;
    localparam int DLY_W   = 32;
    localparam int ARG_W   = 20;

    // field positions inside a program word
    localparam int SET_LO  = 0;
    localparam int CLR_LO  = 32;
    localparam int DLY_LO  = 64;
    localparam int ARG_LO  = 96;
    localparam int OPC_LO  = 116;
    localparam int OPC_W   = 4;

    localparam logic [OPC_W-1:0] OPC_HALT = 4'd0;
    localparam logic [OPC_W-1:0] OPC_LOOP = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ENDL = 4'd3;
    localparam logic [OPC_W-1:0] OPC_CALL = 4'd4;
    localparam logic [OPC_W-1:0] OPC_RET  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_JMP  = 4'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_APPLY,
        ST_HOLD
    } seq_state_e;

endpackage

// File: rtl/patseq_stack.sv
module patseq_stack #(
    parameter int DEPTH  = 256,
    parameter int AW     = 12,
    parameter int CW     = 20,
    localparam int SPW   = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           push,
    input  logic           pop,
    input  logic           dec,
    input  logic [AW-1:0]  push_addr,
    input  logic [CW-1:0]  push_cnt,
    output logic [AW-1:0]  top_addr,
    output logic [CW-1:0]  top_cnt,
    output logic [SPW-1:0] depth,
    output logic           full,
    output logic           empty
);

    logic [AW-1:0] addr_mem [DEPTH];
    logic [CW-1:0] cnt_mem  [DEPTH];
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] top_idx;

    assign full    = (depth == SPW'(DEPTH));
    assign empty   = (depth == '0);
    assign wr_idx  = IW'(depth);
    assign top_idx = IW'(depth - SPW'(1));
    assign top_addr = addr_mem[top_idx];
    assign top_cnt  = cnt_mem[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            depth <= '0;
        else if (push && !full)
            depth <= depth + SPW'(1);
        else if (pop && !empty)
            depth <= depth - SPW'(1);
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            addr_mem[wr_idx] <= push_addr;
            cnt_mem[wr_idx]  <= push_cnt;
        end else if (dec && !empty) begin
            cnt_mem[top_idx] <= top_cnt - CW'(1);
        end
    end

endmodule

// File: rtl/patseq_hold.sv
module patseq_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         last
);

    assign last = (count == W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - W'(1);
    end

endmodule

// File: rtl/patseq_core.sv
module patseq_core
    import patseq_pkg::*;
#(
    parameter int PC_W        = 12,
    parameter int STACK_DEPTH = 256,
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              ext_sel,
    input  logic              ext_start,
    input  logic [PC_W-1:0]   start_addr,
    output logic [PC_W-1:0]   prog_addr,
    input  logic [INSN_W-1:0] prog_data,
    output logic [PAT_W-1:0]  pattern,
    output logic              running,
    output logic              fault,
    output logic [PC_W-1:0]   pc_o,
    output logic [SP_W-1:0]   sp_o,
    output logic [DLY_W-1:0]  dly_o
);

    seq_state_e state, state_nxt;

    logic [PC_W-1:0]   pc, pc_inc, pc_nxt, target;
    logic [INSN_W-1:0] ir;
    logic              ext_q, ext_rise, start_go, stop, apply_go;
    logic [OPC_W-1:0]  opc;
    logic [ARG_W-1:0]  arg, loop_cnt;
    logic [DLY_W-1:0]  hold_val;
    logic [PAT_W-1:0]  set_m, clr_m;
    logic              want_push, want_pop, want_dec, is_halt, is_err;
    logic [PC_W-1:0]   top_addr;
    logic [ARG_W-1:0]  top_cnt, push_cnt;
    logic              stk_full, stk_empty, hold_last;
    logic              unused_bits;

    // field extraction
    assign set_m    = ir[SET_LO +: PAT_W];
    assign clr_m    = ir[CLR_LO +: PAT_W];
    assign hold_val = ir[DLY_LO +: DLY_W];
    assign arg      = ir[ARG_LO +: ARG_W];
    assign opc      = ir[OPC_LO +: OPC_W];
    assign target   = arg[PC_W-1:0];
    assign loop_cnt = (arg == '0) ? ARG_W'(1) : arg;   // R6: zero count runs once
    assign unused_bits = ^{ir[INSN_W-1:OPC_LO+OPC_W], arg};   // R9: top byte unused

    assign pc_inc   = pc + PC_W'(1);
    assign ext_rise = ext_start && !ext_q;
    assign start_go = (state == ST_IDLE) && (ext_sel ? ext_rise : run_req);
    assign stop     = (state != ST_IDLE) && ext_sel && !ext_start;   // R12
    assign apply_go = (state == ST_APPLY) && !stop;

    // control step of the instruction held in ir
    always_comb begin
        want_push = 1'b0;
        want_pop  = 1'b0;
        want_dec  = 1'b0;
        is_halt   = 1'b0;
        is_err    = 1'b0;
        push_cnt  = '0;
        pc_nxt    = pc_inc;
        case (opc)
            OPC_HALT: is_halt = 1'b1;
            OPC_LOOP: begin
                is_err    = stk_full;
                want_push = 1'b1;
                push_cnt  = loop_cnt;
            end
            OPC_ENDL: begin
                is_err = stk_empty;
                if (top_cnt > ARG_W'(1)) begin
                    want_dec = 1'b1;
                    pc_nxt   = top_addr;
                end else begin
                    want_pop = 1'b1;
                end
            end
            OPC_CALL: begin
                is_err    = stk_full;
                want_push = 1'b1;
                pc_nxt    = target;
            end
            OPC_RET: begin
                is_err   = stk_empty;
                want_pop = 1'b1;
                pc_nxt   = top_addr;
            end
            OPC_JMP: pc_nxt = target;
            default: ;   // continue
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start_go) state_nxt = ST_FETCH;
            ST_FETCH: state_nxt = ST_LOAD;
            ST_LOAD:  state_nxt = ST_APPLY;
            ST_APPLY: begin
                if (is_halt || is_err)
                    state_nxt = ST_IDLE;
                else if (hold_val != '0)
                    state_nxt = ST_HOLD;
                else
                    state_nxt = ST_FETCH;
            end
            ST_HOLD:  if (hold_last) state_nxt = ST_FETCH;
        endcase
        if (stop)
            state_nxt = ST_IDLE;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            ir      <= '0;
            pattern <= '0;
            fault   <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            ext_q <= ext_start;
            if (start_go) begin
                pc    <= start_addr;
                fault <= 1'b0;
            end
            if (state == ST_LOAD)
                ir <= prog_data;
            if (apply_go) begin
                pattern <= (pattern & ~clr_m) | set_m;   // R2: set wins
                if (is_err)
                    fault <= 1'b1;                       // R10, R11
                else if (!is_halt)
                    pc <= pc_nxt;
            end
        end
    end

    assign running   = (state != ST_IDLE);
    assign prog_addr = pc;
    assign pc_o      = pc;

    patseq_stack #(
        .DEPTH (STACK_DEPTH),
        .AW    (PC_W),
        .CW    (ARG_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start_go),
        .push      (apply_go && want_push),
        .pop       (apply_go && want_pop),
        .dec       (apply_go && want_dec),
        .push_addr (pc_inc),
        .push_cnt  (push_cnt),
        .top_addr  (top_addr),
        .top_cnt   (top_cnt),
        .depth     (sp_o),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    patseq_hold #(
        .W (DLY_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stop),
        .load     (apply_go && !is_halt && !is_err),
        .load_val (hold_val),
        .count    (dly_o),
        .last     (hold_last)
    );

endmodule

// File: rtl/patseq_core_chk.sv
module patseq_core_chk #(
    parameter int PC_W        = 12,
    parameter int STACK_DEPTH = 256,
    localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_sel,
    input logic            ext_start,
    input logic [31:0]     pattern,
    input logic            running,
    input logic            fault,
    input logic [PC_W-1:0] pc_o,
    input logic [SP_W-1:0] sp_o,
    input logic [31:0]     dly_o
);

    logic unused_pc;
    assign unused_pc = ^pc_o;

    a_r2_pattern_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern != $past(pattern)) |-> $past(running));

    a_r10_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o <= SP_W'(STACK_DEPTH));

    a_r10_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !running);

    a_r4_start_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !fault);

    a_r12_gate_low_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ext_sel && !ext_start) |=> !running);

    a_r13_hold_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dly_o != 32'd0) |=> (!running || dly_o == $past(dly_o) - 32'd1));

endmodule

bind patseq_core patseq_core_chk #(
    .PC_W        (PC_W),
    .STACK_DEPTH (STACK_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_sel   (ext_sel),
    .ext_start (ext_start),
    .pattern   (pattern),
    .running   (running),
    .fault     (fault),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .dly_o     (dly_o)
);

// File: tb/patseq_core_test.sv
module patseq_core_test;

    localparam int PCW = 6;
    localparam int SD  = 4;
    localparam int NW  = 1 << PCW;
    localparam int CAP = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0;
    logic ext_sel = 1'b0;
    logic ext_start = 1'b0;
    logic [PCW-1:0] start_addr = '0;
    logic [PCW-1:0] prog_addr;
    logic [127:0] prog_q;
    logic [31:0] pattern;
    logic running, fault;
    logic [PCW-1:0] pc_o;
    logic [2:0] sp_o;
    logic [31:0] dly_o;

    logic [127:0] prog [NW];

    int total = 0;
    int bad = 0;

    logic [31:0] exp_pat [CAP];
    logic        exp_run [CAP];
    logic [31:0] act_pat [CAP];
    logic        act_run [CAP];
    logic [31:0] act_dly [CAP];
    logic [PCW-1:0] act_pc [CAP];
    int m_len, m_sp;
    bit m_fault;

    always #10 clk = ~clk;

    always_ff @(posedge clk) prog_q <= prog[prog_addr];

    patseq_core #(.PC_W(PCW), .STACK_DEPTH(SD)) uut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .ext_sel(ext_sel),
        .ext_start(ext_start), .start_addr(start_addr), .prog_addr(prog_addr),
        .prog_data(prog_q), .pattern(pattern), .running(running), .fault(fault),
        .pc_o(pc_o), .sp_o(sp_o), .dly_o(dly_o)
    );

    function automatic logic [127:0] ins(input int op, input int arg, input int dly,
                                         input logic [31:0] clr, input logic [31:0] set,
                                         input logic [7:0] hi = 8'h00);
        return {hi, 4'(op), 20'(arg), 32'(dly), clr, set};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // predicted trace from the requirements, sampled at negedges after the start edge
    task automatic model(input int sa, input logic [31:0] p0);
        int pc, sp, nxt;
        int st_a [SD];
        int st_c [SD];
        logic [127:0] w;
        logic [31:0] p;
        int op, arg, d;
        bit done, err, halt;
        int t;
        p = p0; pc = sa; sp = 0; t = 0; done = 0; m_fault = 0; m_len = 0;
        while (!done && t + 3 < CAP) begin
            for (int k = 0; k < 3; k++) begin exp_pat[t] = p; exp_run[t] = 1'b1; t++; end
            w = prog[pc];
            op = int'(w[119:116]); arg = int'(w[115:96]); d = int'(w[95:64]);
            p = (p & ~w[63:32]) | w[31:0];
            nxt = (pc + 1) % NW; err = 0; halt = 0;
            case (op)
                0: halt = 1;
                2: if (sp == SD) err = 1; else begin st_a[sp] = nxt; st_c[sp] = (arg == 0) ? 1 : arg; sp++; end
                3: if (sp == 0) err = 1;
                   else if (st_c[sp-1] > 1) begin st_c[sp-1]--; nxt = st_a[sp-1]; end
                   else sp--;
                4: if (sp == SD) err = 1; else begin st_a[sp] = nxt; st_c[sp] = 0; sp++; nxt = arg % NW; end
                5: if (sp == 0) err = 1; else begin sp--; nxt = st_a[sp]; end
                6: nxt = arg % NW;
                default: ;
            endcase
            if (halt || err) begin
                m_fault = err; exp_pat[t] = p; exp_run[t] = 1'b0; m_len = t + 1; done = 1;
            end else begin
                pc = nxt;
                for (int k = 0; k < d && t < CAP; k++) begin exp_pat[t] = p; exp_run[t] = 1'b1; t++; end
            end
        end
        m_sp = sp;
    endtask

    // called at a negedge; pulses run, records, compares with the model
    task automatic run_case(input string req, input int sa, input int poke_t);
        int first_bad;
        logic [31:0] ep;
        logic er;
        model(sa, pattern);
        check(m_len > 0 && m_len + 2 < CAP, req, "model length", 64'(m_len), 64'(1));
        start_addr = PCW'(sa);
        run_req = 1'b1;
        @(negedge clk);
        run_req = 1'b0;
        for (int t = 0; t < m_len + 2; t++) begin
            if (t > 0) @(negedge clk);
            act_pat[t] = pattern; act_run[t] = running; act_dly[t] = dly_o; act_pc[t] = pc_o;
            if (t == poke_t) begin run_req = 1'b1; start_addr = PCW'(sa + 7); end
            else run_req = 1'b0;
        end
        first_bad = -1;
        for (int t = 0; t < m_len + 2; t++) begin
            ep = (t < m_len) ? exp_pat[t] : exp_pat[m_len-1];
            er = (t < m_len) ? exp_run[t] : 1'b0;
            if (first_bad < 0 && (act_pat[t] !== ep || act_run[t] !== er)) first_bad = t;
        end
        if (first_bad >= 0)
            check(0, req, $sformatf("trace at cycle %0d {run,pat}", first_bad),
                  {31'd0, act_run[first_bad], act_pat[first_bad]},
                  {31'd0, (first_bad < m_len) ? exp_run[first_bad] : 1'b0,
                   (first_bad < m_len) ? exp_pat[first_bad] : exp_pat[m_len-1]});
        else
            check(1, req, "trace", 0, 0);
        check(fault === m_fault, req, "fault after run", 64'(fault), 64'(m_fault));
        check(sp_o == 3'(m_sp), req, "stack depth after run", 64'(sp_o), 64'(m_sp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] p0;
        for (int i = 0; i < NW; i++) prog[i] = '0;
        // P1 at 0: masks, hold timing, ignored high byte, halt (R2 R3 R5 R9)
        prog[0]  = ins(1, 0, 2, 32'h0, 32'hFF);
        prog[1]  = ins(9, 0, 0, 32'hF, 32'hF00, 8'hA5);
        prog[2]  = ins(0, 0, 5, 32'h1, 32'h1);
        // P2 at 4: nested loops, zero count (R6)
        prog[4]  = ins(2, 2, 0, 0, 0);
        prog[5]  = ins(1, 0, 1, 32'h1, 32'h2);
        prog[6]  = ins(2, 0, 0, 0, 0);
        prog[7]  = ins(7, 0, 0, 32'h2, 32'h1);
        prog[8]  = ins(3, 0, 0, 0, 0);
        prog[9]  = ins(2, 3, 2, 0, 0);
        prog[10] = ins(1, 0, 0, 32'h20, 32'h10);
        prog[11] = ins(3, 0, 1, 32'h10, 32'h20);
        prog[12] = ins(3, 0, 0, 0, 0);
        prog[13] = ins(0, 0, 0, 0, 32'h400);
        // P3 at 16: calls, nested call, return, jump (R7 R8)
        prog[16] = ins(4, 24, 0, 0, 32'h100);
        prog[17] = ins(6, 28, 1, 0, 0);
        prog[24] = ins(1, 0, 1, 32'h100, 32'h200);
        prog[25] = ins(5, 0, 0, 0, 0);
        prog[28] = ins(4, 32, 0, 0, 0);
        prog[29] = ins(0, 0, 0, 0, 32'h8000_0000);
        prog[32] = ins(4, 24, 2, 0, 0);
        prog[33] = ins(5, 0, 0, 32'h200, 0);
        // overflow and underflow (R10 R11)
        prog[40] = ins(4, 40, 0, 0, 32'h1000);
        prog[50] = ins(5, 0, 0, 0, 0);
        prog[51] = ins(3, 0, 0, 0, 0);
        // external start program (R12)
        prog[56] = ins(1, 0, 4, 0, 32'hF000);
        prog[57] = ins(4, 60, 0, 0, 32'hFF0000);
        prog[60] = ins(0, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pattern == 32'h0, "R1", "pattern after reset", 64'(pattern), 0);
        check(running == 1'b0, "R1", "running after reset", 64'(running), 0);
        check(fault == 1'b0, "R1", "fault after reset", 64'(fault), 0);
        check(sp_o == 3'd0 && dly_o == 32'd0, "R1", "depth/hold after reset", {sp_o, dly_o}, 0);

        // R2 R3 R5 R9, with an overlapping run pulse for R4
        run_case("R3 R5 R9 R4 masks/hold/halt", 0, 2);
        check(act_pat[11] == 32'hFF1, "R2", "set beats clear", 64'(act_pat[11]), 64'hFF1);
        check(act_dly[3] == 32'd2 && act_dly[4] == 32'd1 && act_dly[5] == 32'd0, "R13",
              "hold countdown", {act_dly[3][15:0], act_dly[4][15:0], act_dly[5][15:0]}, 64'h0002_0001_0000);
        check(act_pc[3] == PCW'(1), "R13", "pc after first apply", 64'(act_pc[3]), 1);

        @(negedge clk);
        run_case("R6 nested loops", 4, -1);
        @(negedge clk);
        run_case("R7 R8 call/return/jump", 16, -1);
        @(negedge clk);
        run_case("R10 overflow", 40, -1);
        check(fault == 1'b1 && sp_o == 3'(SD), "R10", "fault with full stack", {fault, sp_o}, {1'b1, 3'(SD)});
        @(negedge clk);
        check(fault == 1'b1, "R10", "fault sticky while idle", 64'(fault), 1);
        run_case("R11 return underflow", 50, -1);
        @(negedge clk);
        run_case("R11 loop end underflow", 51, -1);
        @(negedge clk);
        run_case("R10 fault cleared by new start", 0, -1);
        check(fault == 1'b0, "R10", "fault after clean run", 64'(fault), 0);

        // R12: external start mode
        @(negedge clk);
        ext_sel = 1'b1;
        start_addr = PCW'(56);
        run_req = 1'b1;
        @(negedge clk);
        run_req = 1'b0;
        repeat (3) @(negedge clk);
        check(running == 1'b0, "R12", "run pulse ignored in external mode", 64'(running), 0);
        p0 = pattern;
        ext_start = 1'b1;
        for (int t = 0; t <= 10; t++) begin
            @(negedge clk);
            if (t == 0) check(running == 1'b1, "R12", "rising gate starts", 64'(running), 1);
            if (t == 3) check(pattern == (p0 | 32'hF000), "R12", "first apply", 64'(pattern), 64'(p0 | 32'hF000));
            if (t == 9) begin
                check(running == 1'b1, "R12", "still running before stop", 64'(running), 1);
                ext_start = 1'b0;
            end
            if (t == 10) begin
                check(running == 1'b0, "R12", "gate low stops", 64'(running), 0);
                check(pattern == (p0 | 32'hF000), "R12", "colliding apply dropped",
                      64'(pattern), 64'(p0 | 32'hF000));
                check(sp_o == 3'd0 && dly_o == 32'd0, "R12", "no push on stop edge", {sp_o, dly_o}, 0);
            end
        end
        ext_sel = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule